// File: doc/BRIEF.md
# USB Host Controller Run/Halt and Schedule Control

This block holds the command and status state of a high-speed USB host controller. Software sets or clears Run, starts a controller reset, and turns the asynchronous and periodic schedules on and off through a single command write strobe. The block reports the halted flag, the host-error flag, reset-busy and the two schedule status bits through a combinational read port.

A parity error on any of three monitored data paths stops the controller at once when error response is enabled. At most one more packet then completes before the controller reports halted, and Run stays locked out until a software reset has run for a set number of 1 ms frame ticks. The block also issues the first fetch requests for each schedule. The asynchronous queue head is requested right away. The periodic frame-list entry is requested on the next frame tick. Both requests wait for Run and bus-master enable. It also drives a memory-access permission that drops when the schedules are paused, while SOF generation follows Run alone.

Top module: `usb_hc_cmd_ctrl`

## Requirements
- R1: When `perr_resp_en_i` is 1, a pulse on any of `perr_wr_i`, `perr_rdc_i` or `perr_aux_i` sets host error and clears Run on the next clock edge. With `perr_resp_en_i` at 0 the pulse has no effect.
- R2: After a host error stops a running controller, halted (status bit 0) stays 0 until the next `pkt_done_i` or `frame_tick_i` pulse, and is 1 in the cycle after it.
- R3: While host error or reset-busy is 1, a command write with the Run bit (bit 0) set leaves Run at 0.
- R4: A command write with bit 1 set starts a reset. Reset-busy (command bit 1, status bit 2) reads 1 for exactly `RST_TICKS` frame ticks. On completion it clears host error, Run and both schedule enables, and it sets halted.
- R5: While halted and in host error, reads still return the current state. Command word: bit0 Run, bit1 busy, bit2 periodic enable, bit3 async enable. Status word: bit0 halted, bit1 host error, bit2 busy, bit3 periodic status, bit4 async status.
- R6: A write that sets a schedule enable (bit 2 periodic, bit 3 async) makes the matching status bit 1 in the next cycle. The two enables may be set by separate writes.
- R7: When the async enable is set while Run and `bus_master_en_i` are 1, `async_fetch_o` is 1 for exactly one cycle, the cycle after the write.
- R8: `periodic_fetch_o` is never 1 without `frame_tick_i`. After the periodic enable is set, it fires on the first frame tick at which Run and `bus_master_en_i` are 1.
- R9: With Run at 0, no fetch is issued even if enables are 1. A pending async fetch is issued once Run is later set.
- R10: `sof_en_o` equals Run. `mem_access_en_o` is 1 only when Run, bus-master enable and at least one schedule enable are 1 and host error is 0.
- R11: A schedule status bit stays 1 after its enable is cleared, and goes to 0 after the next frame tick.
- R12: Out of reset the controller is halted with everything else at 0. A software write that clears Run sets halted after the next packet completion or frame tick. Setting Run clears halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_wr_i | input | 1 | Command register write strobe |
| cmd_wdata_i | input | 4 | Command write data: bit0 Run, bit1 reset, bit2 periodic enable, bit3 async enable |
| rd_sel_i | input | 1 | Read select: 0 command word, 1 status word |
| rd_data_o | output | 5 | Read data |
| perr_resp_en_i | input | 1 | Parity-error response enable |
| perr_wr_i | input | 1 | Parity error on host write data |
| perr_rdc_i | input | 1 | Parity error on read completion data |
| perr_aux_i | input | 1 | Parity error on the third monitored path |
| pkt_done_i | input | 1 | USB packet completed |
| frame_tick_i | input | 1 | 1 ms frame tick |
| bus_master_en_i | input | 1 | Bus-master enable from configuration space |
| async_fetch_o | output | 1 | Request to fetch the first async queue head |
| periodic_fetch_o | output | 1 | Request to fetch the periodic frame-list entry |
| mem_access_en_o | output | 1 | Schedule memory accesses permitted |
| sof_en_o | output | 1 | SOF generation enabled |

## Verification
The hardest state to reach is a host error raised while schedules are enabled and a fetch is still owed, followed by a lockout and a full reset. The stimulus first starts the controller with the async schedule on, then pulses each parity path with response disabled and then enabled. While the error persists it tries to restart Run, then reads back both words and counts the reset out tick by tick. A sweep over Run and bus-master enable covers the deferred-fetch case where the enable is written before Run.

// File: rtl/hc_cmd_pkg.sv
package hc_cmd_pkg;
  localparam int CMD_W  = 4;
  localparam int RD_W   = 5;
  localparam int B_RUN  = 0;
  localparam int B_RST  = 1;
  localparam int B_PER  = 2;
  localparam int B_ASY  = 3;
  localparam int N_SCH  = 2;
  localparam int SCH_PER = 0;
  localparam int SCH_ASY = 1;

  typedef struct packed {
    logic asy_sts;
    logic per_sts;
    logic busy;
    logic herr;
    logic halted;
  } sts_word_t;

  typedef struct packed {
    logic zero;
    logic asy_en;
    logic per_en;
    logic busy;
    logic run;
  } cmd_word_t;
endpackage

// File: rtl/hc_rst_timer.sv
module hc_rst_timer #(
  parameter int RST_TICKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic tick_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(RST_TICKS + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  assign done_o = busy_q & tick_i & (cnt_q == CW'(RST_TICKS - 1));
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (done_o) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q && tick_i) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !tick_i |=> busy_q); // R4
  AST_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_q |=> busy_q && cnt_q == '0); // R4
endmodule

// File: rtl/hc_run_ctrl.sv
module hc_run_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic run_wr_i,
  input  logic perr_hit_i,
  input  logic rst_busy_i,
  input  logic rst_done_i,
  input  logic pkt_done_i,
  input  logic tick_i,
  output logic run_o,
  output logic halted_o,
  output logic herr_o
);
  logic run_q, halted_q, herr_q, hpend_q;
  logic set_ok, resolve;

  assign set_ok  = wr_i & run_wr_i & ~herr_q & ~rst_busy_i;
  // a pending halt ends at the next packet or, with nothing in flight, the frame edge
  assign resolve = hpend_q & (pkt_done_i | tick_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      halted_q <= 1'b1;
      herr_q   <= 1'b0;
      hpend_q  <= 1'b0;
    end else if (perr_hit_i) begin
      herr_q   <= 1'b1;
      run_q    <= 1'b0;
      hpend_q  <= run_q | (hpend_q & ~resolve);
      halted_q <= halted_q | resolve;
    end else if (rst_done_i) begin
      herr_q   <= 1'b0;
      run_q    <= 1'b0;
      halted_q <= 1'b1;
      hpend_q  <= 1'b0;
    end else if (wr_i && !run_wr_i && run_q) begin
      run_q    <= 1'b0;
      hpend_q  <= 1'b1;
    end else if (set_ok && !run_q) begin
      run_q    <= 1'b1;
      halted_q <= 1'b0;
      hpend_q  <= 1'b0;
    end else if (resolve) begin
      halted_q <= 1'b1;
      hpend_q  <= 1'b0;
    end
  end

  assign run_o    = run_q;
  assign halted_o = halted_q;
  assign herr_o   = herr_q;

  AST_PERR_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perr_hit_i |=> herr_q && !run_q); // R1
  AST_HALT_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    herr_q && hpend_q && pkt_done_i && !perr_hit_i |=> halted_q); // R2
  AST_RUN_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    herr_q && wr_i && run_wr_i && !rst_done_i |=> !run_q); // R3
  AST_RST_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_done_i && !perr_hit_i |=> !herr_q && halted_q && !run_q); // R4
endmodule

// File: rtl/hc_sched_chan.sv
module hc_sched_chan #(
  parameter bit IMMEDIATE = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic en_wr_i,
  input  logic tick_i,
  input  logic run_i,
  input  logic bme_i,
  input  logic herr_i,
  input  logic rst_done_i,
  output logic en_o,
  output logic sts_o,
  output logic fetch_o
);
  logic en_q, sts_q, pend_q, trig;

  generate
    if (IMMEDIATE) begin : g_now
      assign trig = 1'b1;
    end else begin : g_frame
      assign trig = tick_i;
    end
  endgenerate

  assign fetch_o = pend_q & en_q & run_i & bme_i & ~herr_i & trig;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
    end else if (rst_done_i) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (wr_i) en_q <= en_wr_i;
      if (wr_i && en_wr_i && !en_q)  pend_q <= 1'b1;
      else if (wr_i && !en_wr_i)     pend_q <= 1'b0;
      else if (fetch_o)              pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             sts_q <= 1'b0;
    else if (wr_i && en_wr_i && !rst_done_i) sts_q <= 1'b1;
    else if (tick_i && !en_q)                sts_q <= 1'b0;
  end

  assign en_o  = en_q;
  assign sts_o = sts_q;

  AST_STS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && en_wr_i && !rst_done_i |=> sts_q); // R6
  AST_STS_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !en_q && !(wr_i && en_wr_i) |=> !sts_q); // R11
  AST_FETCH_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_o |=> !fetch_o); // R7
endmodule

// File: rtl/usb_hc_cmd_ctrl.sv
module usb_hc_cmd_ctrl
  import hc_cmd_pkg::*;
#(
  parameter int RST_TICKS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_wr_i,
  input  logic [CMD_W-1:0] cmd_wdata_i,
  input  logic             rd_sel_i,
  output logic [RD_W-1:0]  rd_data_o,
  input  logic             perr_resp_en_i,
  input  logic             perr_wr_i,
  input  logic             perr_rdc_i,
  input  logic             perr_aux_i,
  input  logic             pkt_done_i,
  input  logic             frame_tick_i,
  input  logic             bus_master_en_i,
  output logic             async_fetch_o,
  output logic             periodic_fetch_o,
  output logic             mem_access_en_o,
  output logic             sof_en_o
);
  logic perr_hit, rst_busy, rst_done;
  logic run, halted, herr;
  logic [N_SCH-1:0] en, sts, fetch;
  sts_word_t sts_w;
  cmd_word_t cmd_w;

  assign perr_hit = perr_resp_en_i & (perr_wr_i | perr_rdc_i | perr_aux_i);

  hc_rst_timer #(.RST_TICKS(RST_TICKS)) u_rst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (cmd_wr_i & cmd_wdata_i[B_RST]),
    .tick_i  (frame_tick_i),
    .busy_o  (rst_busy),
    .done_o  (rst_done)
  );

  hc_run_ctrl u_run (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (cmd_wr_i),
    .run_wr_i   (cmd_wdata_i[B_RUN]),
    .perr_hit_i (perr_hit),
    .rst_busy_i (rst_busy),
    .rst_done_i (rst_done),
    .pkt_done_i (pkt_done_i),
    .tick_i     (frame_tick_i),
    .run_o      (run),
    .halted_o   (halted),
    .herr_o     (herr)
  );

  generate
    for (genvar i = 0; i < N_SCH; i++) begin : g_sch
      localparam int EN_BIT = (i == SCH_ASY) ? B_ASY : B_PER;
      hc_sched_chan #(.IMMEDIATE(i == SCH_ASY)) u_ch (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_i       (cmd_wr_i),
        .en_wr_i    (cmd_wdata_i[EN_BIT]),
        .tick_i     (frame_tick_i),
        .run_i      (run),
        .bme_i      (bus_master_en_i),
        .herr_i     (herr),
        .rst_done_i (rst_done),
        .en_o       (en[i]),
        .sts_o      (sts[i]),
        .fetch_o    (fetch[i])
      );
    end
  endgenerate

  assign async_fetch_o    = fetch[SCH_ASY];
  assign periodic_fetch_o = fetch[SCH_PER];
  assign sof_en_o         = run;
  assign mem_access_en_o  = run & ~herr & bus_master_en_i & (|en);

  always_comb begin
    sts_w = '{asy_sts: sts[SCH_ASY], per_sts: sts[SCH_PER], busy: rst_busy,
              herr: herr, halted: halted};
    cmd_w = '{zero: 1'b0, asy_en: en[SCH_ASY], per_en: en[SCH_PER],
              busy: rst_busy, run: run};
    rd_data_o = rd_sel_i ? RD_W'(sts_w) : RD_W'(cmd_w);
  end

  AST_PFETCH_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    periodic_fetch_o |-> frame_tick_i); // R8
  AST_HALT_NO_SOF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perr_hit |=> !sof_en_o && !mem_access_en_o); // R10
endmodule

// File: tb/sim_usb_hc_cmd_ctrl.sv
module sim_usb_hc_cmd_ctrl;
  localparam int RT = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cmd_wr = 0, rd_sel = 0, perr_en = 0, perr_wr = 0, perr_rdc = 0, perr_aux = 0;
  logic pkt = 0, tick = 0, bme = 0;
  logic [3:0] wdata = '0;
  logic [4:0] rd_data;
  logic afetch, pfetch, mem_en, sof_en;
  int nchk = 0, nfail = 0;
  logic last_pf;

  always #10 clk = ~clk;

  usb_hc_cmd_ctrl #(.RST_TICKS(RT)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_wr_i(cmd_wr), .cmd_wdata_i(wdata),
    .rd_sel_i(rd_sel), .rd_data_o(rd_data), .perr_resp_en_i(perr_en),
    .perr_wr_i(perr_wr), .perr_rdc_i(perr_rdc), .perr_aux_i(perr_aux),
    .pkt_done_i(pkt), .frame_tick_i(tick), .bus_master_en_i(bme),
    .async_fetch_o(afetch), .periodic_fetch_o(pfetch),
    .mem_access_en_o(mem_en), .sof_en_o(sof_en)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rd(input logic sel, output int v);
    rd_sel = sel; #1; v = int'(rd_data);
  endtask

  task automatic wr(input logic [3:0] d);
    cmd_wr = 1; wdata = d; @(negedge clk); cmd_wr = 0; wdata = '0;
  endtask

  task automatic do_tick();
    tick = 1; #1 last_pf = pfetch; @(negedge clk); tick = 0;
  endtask

  task automatic do_pkt();
    pkt = 1; @(negedge clk); pkt = 0;
  endtask

  task automatic do_perr(input int p);
    perr_wr = (p == 0); perr_rdc = (p == 1); perr_aux = (p == 2);
    @(negedge clk); perr_wr = 0; perr_rdc = 0; perr_aux = 0;
  endtask

  task automatic clean();
    wr(4'h0); do_tick(); do_tick();
  endtask

  initial begin
    #(200000 * 20);
    nfail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    int v;
    repeat (2) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R12 reset state
    rd(0, v); chk("R12 reset cmd", v, 0);
    rd(1, v); chk("R12 reset sts", v, 1);

    // R7 / R9 / R10 sweep over run and bus-master enable
    for (int r = 0; r < 2; r++) begin
      for (int b = 0; b < 2; b++) begin
        clean();
        bme = logic'(b);
        wr(4'(r) | 4'h8);
        chk("R7 R9 async fetch", int'(afetch), r & b);
        chk("R10 sof", int'(sof_en), r);
        chk("R10 mem access", int'(mem_en), r & b);
        @(negedge clk);
        chk("R7 single pulse", int'(afetch), 0);
        if (r == 0) begin
          wr(4'h9);
          chk("R9 deferred fetch", int'(afetch), b);
          chk("R10 sof after run", int'(sof_en), 1);
        end
      end
    end

    // R8 periodic fetch at frame tick
    for (int b = 0; b < 2; b++) begin
      clean();
      bme = logic'(b);
      wr(4'h5);
      chk("R8 no immediate pfetch", int'(pfetch), 0);
      rd(1, v); chk("R6 per sts set", (v >> 3) & 1, 1);
      do_tick(); chk("R8 pfetch on tick", int'(last_pf), b);
      do_tick(); chk("R8 pfetch once", int'(last_pf), 0);
    end

    // R6 separate writes, R11 delayed clear
    bme = 1;
    clean();
    wr(4'h5); wr(4'hD);
    rd(1, v); chk("R6 both sts", (v >> 3) & 3, 3);
    wr(4'h1);
    rd(1, v); chk("R11 sts held", (v >> 3) & 3, 3);
    rd(0, v); chk("R11 enables cleared", (v >> 2) & 3, 0);
    do_tick();
    rd(1, v); chk("R11 sts cleared", (v >> 3) & 3, 0);

    // R12 software stop and restart
    wr(4'h0);
    rd(1, v); chk("R12 not yet halted", v & 1, 0);
    do_pkt();
    rd(1, v); chk("R12 halted", v & 1, 1);
    wr(4'h1);
    rd(1, v); chk("R12 run clears halted", v & 1, 0);

    // R1..R5 per parity path
    for (int p = 0; p < 3; p++) begin
      wr(4'h9);
      perr_en = 0; do_perr(p);
      rd(1, v); chk("R1 no response", (v >> 1) & 1, 0);
      rd(0, v); chk("R1 run kept", v & 1, 1);
      perr_en = 1; do_perr(p);
      rd(1, v); chk("R1 host error", (v >> 1) & 1, 1);
      rd(0, v); chk("R1 run cleared", v & 1, 0);
      chk("R10 mem off", int'(mem_en), 0);
      chk("R2 not halted", int'(rd_data[0] & rd_sel), 0);
      @(negedge clk);
      rd(1, v); chk("R2 wait packet", v & 1, 0);
      do_pkt();
      rd(1, v); chk("R2 halted", v & 1, 1);
      wr(4'h9);
      rd(0, v); chk("R3 run locked", v & 1, 0);
      rd(1, v); chk("R5 status read", v, 5'h13);
      rd(0, v); chk("R5 cmd read", v, 8);
      wr(4'hA);
      rd(0, v); chk("R4 busy", v, 10);
      wr(4'h9);
      rd(0, v); chk("R3 run locked busy", v & 1, 0);
      for (int t = 0; t < RT - 1; t++) do_tick();
      rd(1, v); chk("R4 busy before end", (v >> 2) & 1, 1);
      do_tick();
      rd(0, v); chk("R4 cmd after reset", v, 0);
      rd(1, v); chk("R4 sts after reset", v & 7, 1);
      wr(4'h1);
      rd(0, v); chk("R4 run unlocked", v & 1, 1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule